// File: doc/BRIEF.md
# JESD204B Transmit Link Sequencer

This block runs the link-layer phase sequence for one JESD204B-style transmit link of `LANES` lanes. Each lane word carries four octets per link clock cycle, so the link clock runs at one fortieth of the serial line rate. While the receiver holds its active-low synchronization request low, every lane sends code group synchronization characters. Once the request is released, the block waits for the next multiframe boundary. It then sends a four-multiframe initial lane alignment sequence and finally passes transport-layer words through as user data.

Two zero-latency ready outputs face the transport layer, and neither one can apply backpressure. Frame-ready opens during the last alignment multiframe, which gives the transport layer one multiframe of warning. Link-ready opens only when user data is flowing. A free-running multiframe counter is sized at run time from the frame parameters F (octets per frame) and K (frames per multiframe). This counter drives a per-slot start-of-multiframe flag. A request that arrives in any phase sends the link back to synchronization.

Top module: `jesd_tx_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, link_ready and frame_ready are low, every lane octet is 0xBC with its control flag set, and somf is 4'b1000.
- R2: When sync_req_n is low at a rising edge, from the next cycle on both ready outputs are low and every lane octet is 0xBC (K28.5) with its control flag set. This holds in every phase.
- R3: A multiframe ends at a rising edge where the word counter sits on its last word. If sync_req_n is high at such an edge while the link is in synchronization, the alignment sequence starts in the next cycle. Counted from the cycle in which the request is released with the counter at word w, the first alignment word appears F*K/4 - w cycles later.
- R4: The alignment sequence is exactly four multiframes long, indexed 0 to 3. In each multiframe, octet 0 is 0x1C (K28.0, flag set) and octet F*K-1 is 0x7C (K28.3, flag set). In multiframe 1, octet 1 is 0x9C (K28.4, flag set). Every other octet carries its octet position within the multiframe modulo 256, with the flag clear.
- R5: frame_ready is high during alignment multiframe 3 and throughout user data. link_ready is high only during user data. Both are low in every other cycle.
- R6: During user data, lane_data equals tx_data in the same cycle and every control flag is clear. Lane l occupies bits 32l+31 to 32l, and its first octet is in the top byte.
- R7: During user data, a high tx_frame_err in a cycle forces every octet of every lane to 0x00 with its flag clear in that same cycle.
- R8: somf is 4'b1000 in the cycle the word counter is at word 0 and 4'b0000 otherwise, in every phase. Bit 3 maps to octet slot bits 31:24 and bit 0 maps to bits 7:0. Control flag lane_k[4l+3-j] belongs to slot j of lane l, where slot 0 is bits 31:24.
- R9: The word counter is cleared by reset, advances once per cycle and wraps after F*K/4 words. It is sized from the current cfg_f and cfg_k, and F*K must be a nonzero multiple of four.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_req_n | input | 1 | Qualified active-low synchronization request |
| cfg_f | input | FW | Octets per frame F |
| cfg_k | input | KW | Frames per multiframe K |
| tx_data | input | LANES*32 | Transport-layer words, four octets per lane |
| tx_frame_err | input | 1 | Transport data invalid in this cycle |
| link_ready | output | 1 | Link accepting user data (zero ready latency) |
| frame_ready | output | 1 | Transport layer may start producing frames |
| somf | output | 4 | Start-of-multiframe flag per octet slot |
| lane_data | output | LANES*32 | Per-lane outgoing octets |
| lane_k | output | LANES*4 | Per-octet control-character flags |

## Verification
The phase and the word counter are registered, and all outputs are decoded from them. A change on sync_req_n therefore shows up one cycle after the edge that samples it. The alignment start and the ready transitions fall one cycle after the edge at which the counter is on its last word. tx_data and tx_frame_err reach lane_data in the same cycle. The bench changes inputs on the falling edge and samples 1 ns later. At each of those points it compares every output against a phase and counter model that it advances once per rising edge. It also separately measures the start delay of the alignment sequence and the somf period for several F and K settings.

// File: rtl/jtx_seq_pkg.sv
package jtx_seq_pkg;

    typedef enum logic [1:0] {
        PH_CGS  = 2'd0,
        PH_ILAS = 2'd1,
        PH_DATA = 2'd2
    } link_ph_e;

    localparam int unsigned ILAS_MFS = 4;
    localparam int unsigned MFW      = $clog2(ILAS_MFS);

    localparam logic [7:0] OCT_SYNC  = 8'hBC;  // K28.5
    localparam logic [7:0] OCT_START = 8'h1C;  // K28.0
    localparam logic [7:0] OCT_ALIGN = 8'h7C;  // K28.3
    localparam logic [7:0] OCT_CFG   = 8'h9C;  // K28.4

endpackage

// File: rtl/jtx_mf_counter.sv
module jtx_mf_counter #(
    parameter int unsigned FW = 8,
    parameter int unsigned KW = 5,
    localparam int unsigned PW = FW + KW,
    localparam int unsigned CW = PW - 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [FW-1:0] cfg_f,
    input  logic [KW-1:0] cfg_k,
    output logic [CW-1:0] word_idx,
    output logic          mf_last
);

    typedef struct packed {
        logic [CW-1:0] w;
    } cnt_t;

    cnt_t          c_d, c_q;
    logic [PW-1:0] mf_octets;
    logic [PW:0]   next_oct;

    always_comb begin
        mf_octets = PW'(cfg_f) * PW'(cfg_k);
        next_oct  = {1'b0, c_q.w, 2'b00} + (PW+1)'(4);
        mf_last   = next_oct >= {1'b0, mf_octets};
        c_d       = c_q;
        c_d.w     = mf_last ? '0 : c_q.w + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign word_idx = c_q.w;

endmodule

// File: rtl/jtx_link_fsm.sv
module jtx_link_fsm
    import jtx_seq_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sync_req_n,
    input  logic           mf_last,
    output link_ph_e       phase,
    output logic [MFW-1:0] ilas_mf
);

    typedef struct packed {
        link_ph_e       ph;
        logic [MFW-1:0] mf;
    } fsm_t;

    fsm_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!sync_req_n) begin
            s_d.ph = PH_CGS;
            s_d.mf = '0;
        end else begin
            case (s_q.ph)
                PH_CGS: begin
                    if (mf_last) begin
                        s_d.ph = PH_ILAS;
                        s_d.mf = '0;
                    end
                end
                PH_ILAS: begin
                    if (mf_last) begin
                        if (s_q.mf == MFW'(ILAS_MFS - 1)) s_d.ph = PH_DATA;
                        else                              s_d.mf = s_q.mf + 1'b1;
                    end
                end
                PH_DATA: s_d.ph = PH_DATA;
                default: s_d.ph = PH_CGS;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ph <= PH_CGS;
            s_q.mf <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign phase   = s_q.ph;
    assign ilas_mf = s_q.mf;

endmodule

// File: rtl/jtx_lane_fmt.sv
module jtx_lane_fmt
    import jtx_seq_pkg::*;
#(
    parameter int unsigned CW = 11,
    localparam int unsigned OW = CW + 2
) (
    input  link_ph_e       phase,
    input  logic [MFW-1:0] ilas_mf,
    input  logic [CW-1:0]  word_idx,
    input  logic           mf_last,
    input  logic [31:0]    usr_word,
    input  logic           frame_err,
    output logic [31:0]    lane_word,
    output logic [3:0]     lane_kf
);

    logic [7:0] slot_oct [4];
    logic       slot_k   [4];

    for (genvar j = 0; j < 4; j++) begin : g_slot
        logic [OW-1:0] pos;

        always_comb begin
            pos = {word_idx, 2'(j)};
            slot_oct[j] = OCT_SYNC;
            slot_k[j]   = 1'b1;
            case (phase)
                PH_ILAS: begin
                    if (pos == '0) begin
                        slot_oct[j] = OCT_START;
                    end else if (mf_last && j == 3) begin
                        slot_oct[j] = OCT_ALIGN;
                    end else if (ilas_mf == MFW'(1) && pos == OW'(1)) begin
                        slot_oct[j] = OCT_CFG;
                    end else begin
                        slot_oct[j] = pos[7:0];
                        slot_k[j]   = 1'b0;
                    end
                end
                PH_DATA: begin
                    slot_oct[j] = frame_err ? 8'h00 : usr_word[31-8*j -: 8];
                    slot_k[j]   = 1'b0;
                end
                default: begin
                    slot_oct[j] = OCT_SYNC;
                    slot_k[j]   = 1'b1;
                end
            endcase
        end
    end

    assign lane_word = {slot_oct[0], slot_oct[1], slot_oct[2], slot_oct[3]};
    assign lane_kf   = {slot_k[0], slot_k[1], slot_k[2], slot_k[3]};

endmodule

// File: rtl/jesd_tx_seq.sv
module jesd_tx_seq
    import jtx_seq_pkg::*;
#(
    parameter int unsigned LANES = 2,
    parameter int unsigned FW    = 8,
    parameter int unsigned KW    = 5,
    localparam int unsigned CW   = FW + KW - 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sync_req_n,
    input  logic [FW-1:0]         cfg_f,
    input  logic [KW-1:0]         cfg_k,
    input  logic [LANES*32-1:0]   tx_data,
    input  logic                  tx_frame_err,
    output logic                  link_ready,
    output logic                  frame_ready,
    output logic [3:0]            somf,
    output logic [LANES*32-1:0]   lane_data,
    output logic [LANES*4-1:0]    lane_k
);

    logic [CW-1:0]  word_idx;
    logic           mf_last;
    link_ph_e       phase;
    logic [MFW-1:0] ilas_mf;

    jtx_mf_counter #(.FW(FW), .KW(KW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_f    (cfg_f),
        .cfg_k    (cfg_k),
        .word_idx (word_idx),
        .mf_last  (mf_last)
    );

    jtx_link_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_req_n (sync_req_n),
        .mf_last    (mf_last),
        .phase      (phase),
        .ilas_mf    (ilas_mf)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        jtx_lane_fmt #(.CW(CW)) u_fmt (
            .phase     (phase),
            .ilas_mf   (ilas_mf),
            .word_idx  (word_idx),
            .mf_last   (mf_last),
            .usr_word  (tx_data[32*l +: 32]),
            .frame_err (tx_frame_err),
            .lane_word (lane_data[32*l +: 32]),
            .lane_kf   (lane_k[4*l +: 4])
        );
    end

    assign link_ready  = (phase == PH_DATA);
    assign frame_ready = (phase == PH_DATA) ||
                         (phase == PH_ILAS && ilas_mf == MFW'(ILAS_MFS - 1));
    assign somf        = (word_idx == '0) ? 4'b1000 : 4'b0000;

endmodule

// File: rtl/jtx_seq_chk.sv
module jtx_seq_chk #(
    parameter int unsigned LANES = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sync_req_n,
    input logic               link_ready,
    input logic               frame_ready,
    input logic [3:0]         somf,
    input logic [LANES*4-1:0] lane_k
);

    p_sync_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_req_n |=> (!link_ready && !frame_ready));

    p_sync_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_req_n |=> (&lane_k));

    p_link_in_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
        link_ready |-> frame_ready);

    p_link_after_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_ready) |-> $past(frame_ready));

    p_data_no_ctrl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        link_ready |-> (lane_k == '0));

    p_somf_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (somf[2:0] == 3'b000));

endmodule

bind jesd_tx_seq jtx_seq_chk #(.LANES(LANES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_req_n  (sync_req_n),
    .link_ready  (link_ready),
    .frame_ready (frame_ready),
    .somf        (somf),
    .lane_k      (lane_k)
);

// File: tb/tb_jesd_tx_seq.sv
module tb_jesd_tx_seq;

    localparam int LANES = 2;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                sync_req_n = 1'b0;
    logic [7:0]          cfg_f = 8'd2;
    logic [4:0]          cfg_k = 5'd4;
    logic [LANES*32-1:0] tx_data = '0;
    logic                tx_frame_err = 1'b0;
    logic                link_ready, frame_ready;
    logic [3:0]          somf;
    logic [LANES*32-1:0] lane_data;
    logic [LANES*4-1:0]  lane_k;

    int nchk = 0;
    int nerr = 0;
    int m_ph = 0;
    int m_mf = 0;
    int m_w  = 0;

    jesd_tx_seq #(.LANES(LANES)) dut (
        .clk(clk), .rst_n(rst_n), .sync_req_n(sync_req_n),
        .cfg_f(cfg_f), .cfg_k(cfg_k), .tx_data(tx_data),
        .tx_frame_err(tx_frame_err), .link_ready(link_ready),
        .frame_ready(frame_ready), .somf(somf),
        .lane_data(lane_data), .lane_k(lane_k)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int wpm();
        return (int'(cfg_f) * int'(cfg_k)) / 4;
    endfunction

    task automatic check_model();
        int mo;
        string tg;
        mo = int'(cfg_f) * int'(cfg_k);
        tg = (m_ph == 0) ? "R2" : (m_ph == 1) ? "R4" : (tx_frame_err ? "R7" : "R6");
        chk("R5 link_ready", 64'(link_ready), 64'(m_ph == 2));
        chk("R5 frame_ready", 64'(frame_ready), 64'(m_ph == 2 || (m_ph == 1 && m_mf == 3)));
        chk("R8 somf", 64'(somf), (m_w == 0) ? 64'h8 : 64'h0);
        for (int l = 0; l < LANES; l++) begin
            logic [31:0] ew;
            logic [3:0]  ek;
            for (int j = 0; j < 4; j++) begin
                int o;
                logic [7:0] b;
                logic       k;
                o = m_w * 4 + j;
                if (m_ph == 0) begin b = 8'hBC; k = 1'b1; end
                else if (m_ph == 1) begin
                    if (o == 0)                      begin b = 8'h1C; k = 1'b1; end
                    else if (o == mo - 1)            begin b = 8'h7C; k = 1'b1; end
                    else if (m_mf == 1 && o == 1)    begin b = 8'h9C; k = 1'b1; end
                    else                             begin b = 8'(o); k = 1'b0; end
                end else begin
                    b = tx_frame_err ? 8'h00 : tx_data[l*32 + 31 - 8*j -: 8];
                    k = 1'b0;
                end
                ew[31-8*j -: 8] = b;
                ek[3-j] = k;
            end
            chk(tg, 64'(lane_data[32*l +: 32]), 64'(ew));
            chk(tg, 64'(lane_k[4*l +: 4]), 64'(ek));
        end
    endtask

    task automatic model_adv();
        bit last;
        last = (m_w + 1 >= wpm());
        if (!sync_req_n) begin m_ph = 0; m_mf = 0; end
        else if (m_ph == 0 && last) begin m_ph = 1; m_mf = 0; end
        else if (m_ph == 1 && last) begin
            if (m_mf == 3) m_ph = 2; else m_mf++;
        end
        m_w = last ? 0 : m_w + 1;
    endtask

    task automatic step(input logic sync_v, input logic ferr_v);
        @(negedge clk);
        sync_req_n   = sync_v;
        tx_frame_err = ferr_v;
        for (int l = 0; l < LANES; l++) tx_data[32*l +: 32] = $urandom;
        #1;
        check_model();
        model_adv();
    endtask

    task automatic t_reset(input int f, input int k);
        @(negedge clk);
        rst_n = 1'b0;
        sync_req_n = 1'b0;
        cfg_f = 8'(f);
        cfg_k = 5'(k);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            #1;
            chk("R1 ready", {62'd0, link_ready, frame_ready}, 64'd0);
            chk("R1 data", 64'(lane_data), {LANES{32'hBCBCBCBC}});
            chk("R1 flags", 64'(lane_k), 64'((1 << (4*LANES)) - 1));
            chk("R1 somf", 64'(somf), 64'h8);
        end
        @(negedge clk);
        rst_n = 1'b1;
        m_ph = 0; m_mf = 0; m_w = 0;
        #1;
        chk("R1 ready after release", {62'd0, link_ready, frame_ready}, 64'd0);
        chk("R1 flags after release", 64'(lane_k), 64'((1 << (4*LANES)) - 1));
        model_adv();
    endtask

    task automatic t_bringup(input int f, input int k, input int ndata);
        int w0, n, per;
        t_reset(f, k);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0);
        w0 = m_w;
        n = 0;
        step(1'b1, 1'b0);
        while (!(lane_data[31:24] == 8'h1C && lane_k[3] && !link_ready) && n < 200) begin
            step(1'b1, 1'b0);
            n++;
        end
        chk("R3 alignment start delay", 64'(n), 64'(wpm() - w0));
        while (!link_ready && n < 400) begin step(1'b1, 1'b0); n++; end
        chk("R5 reached user data", 64'(link_ready), 64'd1);
        for (int i = 0; i < ndata; i++) step(1'b1, 1'b0);
        n = 0;
        while (somf != 4'b1000 && n < 200) begin step(1'b1, 1'b0); n++; end
        per = 0;
        step(1'b1, 1'b0); per++;
        while (somf != 4'b1000 && per < 200) begin step(1'b1, 1'b0); per++; end
        chk("R9 multiframe period", 64'(per), 64'(wpm()));
    endtask

    task automatic t_frame_err();
        step(1'b1, 1'b1);
        chk("R7 zeroed", 64'(lane_data), 64'd0);
        step(1'b1, 1'b1);
        step(1'b1, 1'b0);
        chk("R6 data resumes", 64'(lane_data), 64'(tx_data));
    endtask

    task automatic t_resync_data();
        step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        chk("R2 ready dropped", {62'd0, link_ready, frame_ready}, 64'd0);
        for (int i = 0; i < 40 && !link_ready; i++) step(1'b1, 1'b0);
        chk("R2 relinked", 64'(link_ready), 64'd1);
    endtask

    task automatic t_resync_ilas();
        step(1'b0, 1'b0);
        for (int i = 0; i < 10 && m_ph != 1; i++) step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        chk("R2 back to sync from alignment", 64'(lane_k), 64'((1 << (4*LANES)) - 1));
        for (int i = 0; i < 40 && !link_ready; i++) step(1'b1, 1'b0);
        chk("R2 relinked after alignment abort", 64'(link_ready), 64'd1);
    endtask

    initial begin
        #400000;
        nerr++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        t_bringup(2, 4, 6);
        t_frame_err();
        t_resync_data();
        t_resync_ilas();
        t_bringup(4, 5, 4);
        t_frame_err();
        t_bringup(1, 4, 4);
        t_resync_data();
        t_bringup(3, 4, 3);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule